// File: doc/BRIEF.md
# Fractional PLL Reprogramming Sequencer

This block sits beside a fractional PLL and owns its control pins: the active-low PLL reset, the bypass select, the lock-source select, the packed divider word (feedback divider m, pre-divider p, post-divider s) and the signed 16-bit fractional value k. A client asks for a new setting with a one-cycle request strobe. If m and p already match what the PLL runs with, only s and k are rewritten in place, so the output never glitches through a reset. Otherwise the block walks the PLL through a safe relock: lock source selected, reset asserted, bypass on, all dividers loaded, a settling wait, reset released, a bounded wait for lock, bypass off.

Separate strobes power the PLL up (bypass, release reset, wait for lock, unbypass) and down (reset driven low). Timing intervals are given in microseconds and turned into reference-clock cycles through a cycles-per-microsecond parameter. A busy flag covers each multi-cycle sequence, a one-cycle done pulse ends every accepted command, and an error flag reports a rejected request or a lock timeout. After a timeout the bypass stays on, so downstream logic keeps the reference clock.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset, pllRstN is 0, pllBypass is 0, pllLockSel is 0, divWord holds the initial m, p and s, fracK is 0, and busy, done and errFlag are 0.
- R2: An in-range request whose m and p equal the current ones updates only s and k on the next clock edge, pulses done with errFlag 0, leaves pllRstN and pllBypass unchanged, and never raises busy.
- R3: A request with a different m or p sets pllLockSel and busy on the accepting edge, drives pllRstN low one edge later, sets pllBypass on the next, and loads m, p, s and k on the next; divWord places m in bits 21:12, p in bits 9:4 and s in bits 2:0, with all other bits 0.
- R4: After the dividers load, pllRstN stays low for exactly SETTLE_US*CYC_PER_US edges, then rises on the following edge.
- R5: When pllLock is seen high while waiting, pllBypass clears on the next edge together with a done pulse, errFlag 0 and busy falling.
- R6: If pllLock stays low for LOCK_TIMEOUT_US*CYC_PER_US edges after reset release, done pulses with errFlag 1, busy falls, and pllBypass and pllRstN both stay 1.
- R7: A power-up strobe while pllRstN is already 1 only pulses done with errFlag 0.
- R8: A power-up strobe while pllRstN is 0 raises busy, sets pllBypass one edge later, releases pllRstN on the next, then waits for lock as in R5 and R6.
- R9: A power-down strobe drives pllRstN low on the next edge with a done pulse and errFlag 0; pllBypass and the dividers do not change.
- R10: While busy is 1, request, power-up and power-down strobes are ignored, and done is never 1 while busy is 1.
- R11: A request with p equal to 0, m below 64 or s above 6 changes no output except a done pulse with errFlag 1.
- R12: When strobes coincide while idle, the divider request wins over power-up, and power-up wins over power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset of the block |
| reqValid | input | 1 | One-cycle divider change request |
| reqM | input | 10 | Requested feedback divider m |
| reqP | input | 6 | Requested pre-divider p |
| reqS | input | 3 | Requested post-divider shift s |
| reqK | input | 16 | Requested fractional value k, two's complement |
| pwrUpReq | input | 1 | One-cycle power-up strobe |
| pwrDnReq | input | 1 | One-cycle power-down strobe |
| pllLock | input | 1 | Lock indicator from the PLL |
| pllRstN | output | 1 | PLL reset, active low (low = powered down) |
| pllBypass | output | 1 | PLL bypass select, 1 = reference passed through |
| pllLockSel | output | 1 | Lock source select, 1 = PLL output lock |
| divWord | output | 32 | Packed dividers: m 21:12, p 9:4, s 2:0 |
| fracK | output | 16 | Fractional value k |
| busy | output | 1 | High during a multi-cycle sequence |
| done | output | 1 | One-cycle completion pulse |
| errFlag | output | 1 | Result of the last completed command, 1 = rejected or timed out |

## Verification
The bench builds the block with CYC_PER_US = 2, SETTLE_US = 3 and LOCK_TIMEOUT_US = 20, so the settling wait is 6 edges and the lock timeout 40 edges. That keeps both the settle boundary and a full timeout, followed by a recovery relock, within a few hundred cycles. A lock model in the bench raises pllLock a few cycles after reset release, or never when the timeout case is exercised. Strobes are also issued mid-sequence and in coinciding pairs.

// File: rtl/pll_reprog_pkg.sv
package pll_reprog_pkg;

  localparam int M_W   = 10;
  localparam int P_W   = 6;
  localparam int S_W   = 3;
  localparam int K_W   = 16;
  localparam int DIV_W = 32;

  // field positions decoded by the PLL
  localparam int M_LSB = 12;
  localparam int P_LSB = 4;
  localparam int S_LSB = 0;

  // legal ranges
  localparam int M_MIN = 64;
  localparam int P_MIN = 1;
  localparam int S_MAX = 6;

  typedef enum logic [3:0] {
    S_IDLE,
    S_FRST,
    S_FBYP,
    S_FLOAD,
    S_SETTLE,
    S_PBYP,
    S_REL,
    S_LOCKW,
    S_UNBYP
  } seqState_t;

  typedef struct packed {
    logic selLock;
    logic rstLow;
    logic rstHigh;
    logic bypOn;
    logic bypOff;
    logic capture;
    logic loadAll;
    logic loadFast;
    logic cntClr;
    logic cntInc;
  } seqStrobe_t;

endpackage

// File: rtl/pll_reprog_regs.sv
module pll_reprog_regs
  import pll_reprog_pkg::*;
#(
  parameter int SETTLE_CYC  = 12,
  parameter int TIMEOUT_CYC = 40000,
  parameter int INIT_M      = 64,
  parameter int INIT_P      = 1,
  parameter int INIT_S      = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  input  logic [M_W-1:0]   reqM,
  input  logic [P_W-1:0]   reqP,
  input  logic [S_W-1:0]   reqS,
  input  logic [K_W-1:0]   reqK,
  output logic             pllRstN,
  output logic             pllBypass,
  output logic             pllLockSel,
  output logic [M_W-1:0]   curM,
  output logic [P_W-1:0]   curP,
  output logic [S_W-1:0]   curS,
  output logic [K_W-1:0]   curK,
  output logic             settleDone,
  output logic             lockTimedOut
);

  localparam int TMAX  = (TIMEOUT_CYC > SETTLE_CYC) ? TIMEOUT_CYC : SETTLE_CYC;
  localparam int CNT_W = $clog2(TMAX + 1);

  logic [M_W-1:0]   pendM;
  logic [P_W-1:0]   pendP;
  logic [S_W-1:0]   pendS;
  logic [K_W-1:0]   pendK;
  logic [CNT_W-1:0] tickCnt;

  // pending request captured on acceptance
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendM <= M_W'(INIT_M);
      pendP <= P_W'(INIT_P);
      pendS <= S_W'(INIT_S);
      pendK <= '0;
    end else if (strb.capture) begin
      pendM <= reqM;
      pendP <= reqP;
      pendS <= reqS;
      pendK <= reqK;
    end
  end

  // live divider registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curM <= M_W'(INIT_M);
      curP <= P_W'(INIT_P);
      curS <= S_W'(INIT_S);
      curK <= '0;
    end else if (strb.loadAll) begin
      curM <= pendM;
      curP <= pendP;
      curS <= pendS;
      curK <= pendK;
    end else if (strb.loadFast) begin
      curS <= reqS;
      curK <= reqK;
    end
  end

  // PLL control pins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pllRstN    <= 1'b0;
      pllBypass  <= 1'b0;
      pllLockSel <= 1'b0;
    end else begin
      if (strb.rstLow)       pllRstN   <= 1'b0;
      else if (strb.rstHigh) pllRstN   <= 1'b1;
      if (strb.bypOn)        pllBypass <= 1'b1;
      else if (strb.bypOff)  pllBypass <= 1'b0;
      if (strb.selLock)      pllLockSel <= 1'b1;
    end
  end

  // shared interval counter for settle and lock timeout
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            tickCnt <= '0;
    else if (strb.cntClr) tickCnt <= '0;
    else if (strb.cntInc) tickCnt <= tickCnt + 1'b1;
  end

  assign settleDone   = (tickCnt == CNT_W'(SETTLE_CYC - 1));
  assign lockTimedOut = (tickCnt == CNT_W'(TIMEOUT_CYC - 1));

  // m and p may only move while the PLL is held in reset
  p_div_in_reset_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((curM != $past(curM)) || (curP != $past(curP))) |-> !pllRstN)
    else $error("m/p changed while PLL running");

  // bypass is only removed from a running PLL
  p_unbyp_running_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pllBypass) |-> pllRstN)
    else $error("bypass cleared while PLL in reset");

endmodule

// File: rtl/pll_reprog_ctrl.sv
module pll_reprog_ctrl
  import pll_reprog_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [M_W-1:0]   reqM,
  input  logic [P_W-1:0]   reqP,
  input  logic [S_W-1:0]   reqS,
  input  logic             pwrUpReq,
  input  logic             pwrDnReq,
  input  logic             pllLock,
  input  logic [M_W-1:0]   curM,
  input  logic [P_W-1:0]   curP,
  input  logic             pllRstN,
  input  logic             pllBypass,
  input  logic             settleDone,
  input  logic             lockTimedOut,
  output seqStrobe_t       strb,
  output logic             busy,
  output logic             done,
  output logic             errFlag
);

  seqState_t state, nxtState;
  logic reqOk, sameMP;
  logic setDone, setErr, setBusy, clrBusy;

  assign reqOk  = (reqP >= P_W'(P_MIN)) && (reqM >= M_W'(M_MIN)) && (reqS <= S_W'(S_MAX));
  assign sameMP = (reqM == curM) && (reqP == curP);

  always_comb begin
    strb     = '0;
    nxtState = state;
    setDone  = 1'b0;
    setErr   = 1'b0;
    setBusy  = 1'b0;
    clrBusy  = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          if (!reqOk) begin
            setDone = 1'b1;
            setErr  = 1'b1;
          end else if (sameMP) begin
            strb.loadFast = 1'b1;
            setDone       = 1'b1;
          end else begin
            strb.selLock = 1'b1;
            strb.capture = 1'b1;
            setBusy      = 1'b1;
            nxtState     = S_FRST;
          end
        end else if (pwrUpReq) begin
          if (pllRstN) begin
            setDone = 1'b1;
          end else begin
            setBusy  = 1'b1;
            nxtState = S_PBYP;
          end
        end else if (pwrDnReq) begin
          strb.rstLow = 1'b1;
          setDone     = 1'b1;
        end
      end
      S_FRST: begin
        strb.rstLow = 1'b1;
        nxtState    = S_FBYP;
      end
      S_FBYP: begin
        strb.bypOn = 1'b1;
        nxtState   = S_FLOAD;
      end
      S_FLOAD: begin
        strb.loadAll = 1'b1;
        strb.cntClr  = 1'b1;
        nxtState     = S_SETTLE;
      end
      S_SETTLE: begin
        if (settleDone) nxtState = S_REL;
        else            strb.cntInc = 1'b1;
      end
      S_PBYP: begin
        strb.bypOn = 1'b1;
        nxtState   = S_REL;
      end
      S_REL: begin
        strb.rstHigh = 1'b1;
        strb.cntClr  = 1'b1;
        nxtState     = S_LOCKW;
      end
      S_LOCKW: begin
        if (pllLock) begin
          nxtState = S_UNBYP;
        end else if (lockTimedOut) begin
          setDone  = 1'b1;
          setErr   = 1'b1;
          clrBusy  = 1'b1;
          nxtState = S_IDLE;
        end else begin
          strb.cntInc = 1'b1;
        end
      end
      S_UNBYP: begin
        strb.bypOff = 1'b1;
        setDone     = 1'b1;
        clrBusy     = 1'b1;
        nxtState    = S_IDLE;
      end
      default: nxtState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      busy    <= 1'b0;
      done    <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      state <= nxtState;
      done  <= setDone;
      if (setDone) errFlag <= setErr;
      if (setBusy)      busy <= 1'b1;
      else if (clrBusy) busy <= 1'b0;
    end
  end

  p_busy_done_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done))
    else $error("done while busy");

  p_timeout_keeps_byp_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_LOCKW && !pllLock && lockTimedOut) |=>
      (pllBypass && pllRstN && errFlag && done && !busy))
    else $error("timeout exit wrong");

  p_pwrdn_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && !reqValid && !pwrUpReq && pwrDnReq) |=>
      (!pllRstN && done && !errFlag && $stable(pllBypass)))
    else $error("power-down wrong");

  p_fast_no_reset_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && reqValid && reqOk && sameMP) |=>
      ($stable(pllRstN) && $stable(pllBypass) && done && !busy))
    else $error("fast path touched reset or bypass");

  p_reject_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && reqValid && !reqOk) |=>
      (done && errFlag && $stable(curM) && $stable(curP) && $stable(pllRstN)))
    else $error("bad request not rejected");

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_reprog_pkg::*;
#(
  parameter int CYC_PER_US      = 4,
  parameter int SETTLE_US       = 3,
  parameter int LOCK_TIMEOUT_US = 10000,
  parameter int INIT_M          = 64,
  parameter int INIT_P          = 1,
  parameter int INIT_S          = 0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic [9:0]   reqM,
  input  logic [5:0]   reqP,
  input  logic [2:0]   reqS,
  input  logic [15:0]  reqK,
  input  logic         pwrUpReq,
  input  logic         pwrDnReq,
  input  logic         pllLock,
  output logic         pllRstN,
  output logic         pllBypass,
  output logic         pllLockSel,
  output logic [31:0]  divWord,
  output logic [15:0]  fracK,
  output logic         busy,
  output logic         done,
  output logic         errFlag
);

  localparam int SETTLE_CYC  = SETTLE_US * CYC_PER_US;
  localparam int TIMEOUT_CYC = LOCK_TIMEOUT_US * CYC_PER_US;

  seqStrobe_t       strb;
  logic [M_W-1:0]   curM;
  logic [P_W-1:0]   curP;
  logic [S_W-1:0]   curS;
  logic [K_W-1:0]   curK;
  logic             settleDone, lockTimedOut;

  pll_reprog_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqM         (reqM),
    .reqP         (reqP),
    .reqS         (reqS),
    .pwrUpReq     (pwrUpReq),
    .pwrDnReq     (pwrDnReq),
    .pllLock      (pllLock),
    .curM         (curM),
    .curP         (curP),
    .pllRstN      (pllRstN),
    .pllBypass    (pllBypass),
    .settleDone   (settleDone),
    .lockTimedOut (lockTimedOut),
    .strb         (strb),
    .busy         (busy),
    .done         (done),
    .errFlag      (errFlag)
  );

  pll_reprog_regs #(
    .SETTLE_CYC  (SETTLE_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .INIT_M      (INIT_M),
    .INIT_P      (INIT_P),
    .INIT_S      (INIT_S)
  ) u_regs (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .reqM         (reqM),
    .reqP         (reqP),
    .reqS         (reqS),
    .reqK         (reqK),
    .pllRstN      (pllRstN),
    .pllBypass    (pllBypass),
    .pllLockSel   (pllLockSel),
    .curM         (curM),
    .curP         (curP),
    .curS         (curS),
    .curK         (curK),
    .settleDone   (settleDone),
    .lockTimedOut (lockTimedOut)
  );

  always_comb begin
    divWord = '0;
    divWord[M_LSB +: M_W] = curM;
    divWord[P_LSB +: P_W] = curP;
    divWord[S_LSB +: S_W] = curS;
  end

  assign fracK = curK;

endmodule

// File: tb/sim_pll_reprog_seq.sv
module sim_pll_reprog_seq;

  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 2;
  localparam int SUS        = 3;
  localparam int TUS        = 20;
  localparam int SETTLE_N   = SUS * CPU;
  localparam int TIMEOUT_N  = TUS * CPU;
  localparam int LOCK_DLY   = 3;
  localparam int WATCHDOG   = 20000;

  localparam int A_RST = 0, A_BYP = 1, A_LOAD = 2, A_NOP = 3,
                 A_REL = 4, A_WAIT = 5, A_UNB = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [9:0]  reqM = '0;
  logic [5:0]  reqP = '0;
  logic [2:0]  reqS = '0;
  logic [15:0] reqK = '0;
  logic        pwrUpReq = 1'b0;
  logic        pwrDnReq = 1'b0;
  logic        pllLock = 1'b0;
  logic        pllRstN, pllBypass, pllLockSel, busy, done, errFlag;
  logic [31:0] divWord;
  logic [15:0] fracK;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string curTag = "R1";
  bit armed = 1'b0;
  bit lockOn = 1'b1;
  int lockCnt = 0;

  // reference model state
  logic       mRst = 0, mByp = 0, mSel = 0, mBusy = 0, mDone = 0, mErr = 0;
  logic [9:0] mM = 10'd64, pM;
  logic [5:0] mP = 6'd1,  pP;
  logic [2:0] mS = 3'd0,  pS;
  logic [15:0] mK = '0,   pK;
  int actQ[$];
  int waitCnt = 0;

  pll_reprog_seq #(
    .CYC_PER_US(CPU), .SETTLE_US(SUS), .LOCK_TIMEOUT_US(TUS)
  ) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqM(reqM), .reqP(reqP),
    .reqS(reqS), .reqK(reqK), .pwrUpReq(pwrUpReq), .pwrDnReq(pwrDnReq),
    .pllLock(pllLock), .pllRstN(pllRstN), .pllBypass(pllBypass),
    .pllLockSel(pllLockSel), .divWord(divWord), .fracK(fracK), .busy(busy),
    .done(done), .errFlag(errFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural model, advanced on every rising edge
  always @(posedge clk) begin
    armed = 1'b1;
    mDone = 1'b0;
    if (!rstN) begin
      mRst = 0; mByp = 0; mSel = 0; mBusy = 0; mErr = 0;
      mM = 10'd64; mP = 6'd1; mS = 3'd0; mK = '0;
      actQ.delete();
    end else if (actQ.size() == 0) begin
      if (reqValid) begin
        if (reqP == 0 || reqM < 64 || reqS > 6) begin
          mDone = 1; mErr = 1;
        end else if (reqM == mM && reqP == mP) begin
          mS = reqS; mK = reqK; mDone = 1; mErr = 0;
        end else begin
          pM = reqM; pP = reqP; pS = reqS; pK = reqK;
          mSel = 1; mBusy = 1;
          actQ.push_back(A_RST); actQ.push_back(A_BYP); actQ.push_back(A_LOAD);
          for (int i = 0; i < SETTLE_N; i++) actQ.push_back(A_NOP);
          actQ.push_back(A_REL); actQ.push_back(A_WAIT); actQ.push_back(A_UNB);
        end
      end else if (pwrUpReq) begin
        if (mRst) begin
          mDone = 1; mErr = 0;
        end else begin
          mBusy = 1;
          actQ.push_back(A_BYP); actQ.push_back(A_REL);
          actQ.push_back(A_WAIT); actQ.push_back(A_UNB);
        end
      end else if (pwrDnReq) begin
        mRst = 0; mDone = 1; mErr = 0;
      end
    end else begin
      case (actQ[0])
        A_RST:  begin mRst = 0; void'(actQ.pop_front()); end
        A_BYP:  begin mByp = 1; void'(actQ.pop_front()); end
        A_LOAD: begin mM = pM; mP = pP; mS = pS; mK = pK; void'(actQ.pop_front()); end
        A_NOP:  void'(actQ.pop_front());
        A_REL:  begin mRst = 1; waitCnt = 0; void'(actQ.pop_front()); end
        A_WAIT: begin
          if (pllLock) void'(actQ.pop_front());
          else if (waitCnt == TIMEOUT_N - 1) begin
            mDone = 1; mErr = 1; mBusy = 0; actQ.delete();
          end else waitCnt++;
        end
        A_UNB:  begin mByp = 0; mDone = 1; mErr = 0; mBusy = 0; void'(actQ.pop_front()); end
        default: void'(actQ.pop_front());
      endcase
    end
  end

  // PLL lock stand-in
  always @(negedge clk) begin
    if (!lockOn || !pllRstN) begin
      lockCnt = 0; pllLock = 1'b0;
    end else begin
      if (lockCnt < LOCK_DLY) lockCnt++;
      pllLock = (lockCnt >= LOCK_DLY);
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    logic [31:0] expWord;
    logic [87:0] act, exp;
    cycles++;
    if (armed) begin
      expWord = (32'(mM) << 12) | (32'(mP) << 4) | 32'(mS);
      act = {pllRstN, pllBypass, pllLockSel, busy, done, errFlag, 2'b0, divWord, fracK, 32'd0};
      exp = {mRst, mByp, mSel, mBusy, mDone, mErr, 2'b0, expWord, mK, 32'd0};
      checks++;
      if (act !== exp) begin
        errors++;
        $display("FAIL %s cyc %0d: rst/byp/sel/busy/done/err act %b%b%b%b%b%b exp %b%b%b%b%b%b divWord act %h exp %h k act %h exp %h",
                 curTag, cycles, pllRstN, pllBypass, pllLockSel, busy, done, errFlag,
                 mRst, mByp, mSel, mBusy, mDone, mErr, divWord, expWord, fracK, mK);
      end
    end
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic spot(input string tag, input logic [31:0] actV, input logic [31:0] expV);
    checks++;
    if (actV !== expV) begin
      errors++;
      $display("FAIL %s: act %h exp %h", tag, actV, expV);
    end
  endtask

  task automatic drive(input logic v, input logic up, input logic dn,
                       input logic [9:0] m, input logic [5:0] p,
                       input logic [2:0] s, input logic [15:0] k);
    @(negedge clk);
    reqValid = v; pwrUpReq = up; pwrDnReq = dn;
    reqM = m; reqP = p; reqS = s; reqK = k;
    @(negedge clk);
    reqValid = 0; pwrUpReq = 0; pwrDnReq = 0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!busy && actQ.size() == 0) break;
    end
    @(negedge clk);
  endtask

  initial begin
    curTag = "R1";
    repeat (3) @(negedge clk);
    spot("R1 reset pins", {29'd0, pllRstN, pllBypass, pllLockSel}, 32'd0);
    spot("R1 reset divWord", divWord, 32'h0004_0010);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    curTag = "R9 down while down";
    drive(0, 0, 1, 0, 0, 0, 0); waitIdle();

    curTag = "R8 power-up";
    drive(0, 1, 0, 0, 0, 0, 0); waitIdle();
    spot("R8 running unbypassed", {30'd0, pllRstN, pllBypass}, 32'd2);

    curTag = "R7 power-up when running";
    drive(0, 1, 0, 0, 0, 0, 0); waitIdle();

    curTag = "R2 fast s/k";
    drive(1, 0, 0, 10'd64, 6'd1, 3'd4, 16'hFF00); waitIdle();
    spot("R2 s and k", {divWord[2:0], fracK}, {13'd0, 3'd4, 16'hFF00});

    curTag = "R3 R4 R5 full relock";
    drive(1, 0, 0, 10'd200, 6'd3, 3'd1, 16'h1234); waitIdle();
    spot("R3 divWord fields", divWord, 32'h000C_8031);

    curTag = "R10 ignore while busy";
    drive(1, 0, 0, 10'd350, 6'd3, 3'd2, 16'h0000);
    drive(1, 0, 0, 10'd64, 6'd1, 3'd0, 16'h0001);
    drive(0, 0, 1, 0, 0, 0, 0);
    drive(0, 1, 0, 0, 0, 0, 0);
    waitIdle();
    spot("R10 later strobes ignored", {pllRstN, 21'd0, divWord[21:12]}, {1'b1, 21'd0, 10'd350});

    curTag = "R11 out of range";
    drive(1, 0, 0, 10'd63, 6'd3, 3'd0, 16'h0);  waitIdle();
    drive(1, 0, 0, 10'd300, 6'd0, 3'd0, 16'h0); waitIdle();
    drive(1, 0, 0, 10'd350, 6'd3, 3'd7, 16'h0); waitIdle();
    drive(1, 0, 0, 10'd1023, 6'd63, 3'd6, 16'h7FFF); waitIdle();

    curTag = "R6 lock timeout";
    lockOn = 1'b0;
    drive(1, 0, 0, 10'd300, 6'd3, 3'd1, 16'h8000); waitIdle();
    spot("R6 bypass kept", {29'd0, pllRstN, pllBypass, errFlag}, 32'd7);
    lockOn = 1'b1;
    curTag = "R5 recover";
    drive(1, 0, 0, 10'd250, 6'd2, 3'd2, 16'h0000); waitIdle();

    curTag = "R12 request beats power-down";
    drive(1, 0, 1, 10'd250, 6'd2, 3'd3, 16'h0042); waitIdle();
    curTag = "R12 power-up beats power-down";
    drive(0, 1, 1, 0, 0, 0, 0); waitIdle();
    spot("R12 still running", {31'd0, pllRstN}, 32'd1);

    curTag = "R9 power-down";
    drive(0, 0, 1, 0, 0, 0, 0); waitIdle();
    curTag = "R8 power-up again";
    drive(0, 1, 1, 0, 0, 0, 0); waitIdle();

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule